// File: doc/BRIEF.md
# System Flags Privilege Gate

This block holds the system half of a 16-bit processor flags word and judges, cycle by cycle, whether the instruction that decode presents may execute at the current privilege level. Decode supplies the current privilege level, a two-bit instruction class and, for a flags restore, the word that is being restored. The block answers at once with an allow signal or a general-protection fault strobe carrying error code zero.

A flags restore is never refused. Instead it quietly keeps the bits that the caller is not entitled to change. The I/O privilege level can only be rewritten from level 0. The interrupt-enable bit can only be rewritten from a level at or inside the I/O privilege level.

The task-switch sequencer drives two events into the block. A task switch started by a call or an interrupt sets the nested-task bit. An interrupt that stays within the task clears it. On a return event the block reports the nested-task bit so that the return logic can choose between an in-task return and a return to the linked task.

Top module: `sysflag_gate`

## Requirements
- R1: While reset is active, and in the first cycle after it, the flags word reads 16'h0002. Interrupt-enable (bit 9), nested-task (bit 14) and I/O level (bits 13:12) are all 0.
- R2: For op class 2'b01 (privileged), `allow` is 1 when CPL is 0. At any other CPL, `gp_fault` is 1 and `gp_code` is 16'h0000.
- R3: For op class 2'b10 (trusted: port I/O, interrupt-flag set and clear, lock prefix), `allow` is 1 when CPL is less than or equal to flags bits 13:12. Otherwise `gp_fault` is 1 with `gp_code` 16'h0000.
- R4: For op class 2'b11 (flags restore), bits 13:12 take the new value only when CPL is 0. At any other CPL the old I/O level is kept.
- R5: A flags restore loads bit 9 only when CPL is less than or equal to the I/O level held before the restore. Otherwise the old bit 9 is kept and no fault is raised.
- R6: A call or interrupt task-switch event (`ev_task_call`) sets bit 14 on the next edge. It takes priority over `ev_int_plain` and over the nested-task bit of a restore in the same cycle.
- R7: An interrupt that does not switch tasks (`ev_int_plain`) clears bit 14 on the next edge, overriding a restore in the same cycle.
- R8: `link_sel` equals bit 14 while `ev_return` is 1 (0 selects an in-task return, 1 a return to the linked task) and is 0 otherwise.
- R9: `gp_fault` is asserted only while `op_valid` is 1. In a cycle with `gp_fault` set, the flags word does not change, and any task events in that cycle are dropped.
- R10: A flags restore loads bits 11:10 and 8:0 from `wr_data` and bit 14 from `wr_data[14]`, except that bit 1 always reads 1 and bit 15 always reads 0.
- R11: Op class 2'b00 (ordinary) is always allowed and never faults. With `op_valid` at 0, neither `allow` nor `gp_fault` is asserted, whatever the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl | input | 2 | Current privilege level, 0 most trusted |
| op_valid | input | 1 | A classified instruction is presented this cycle |
| op_class | input | 2 | 00 ordinary, 01 privileged, 10 trusted, 11 flags restore |
| wr_data | input | 16 | Flags word offered by a restore |
| ev_task_call | input | 1 | Task switch started by call or interrupt |
| ev_int_plain | input | 1 | Interrupt taken without a task switch |
| ev_return | input | 1 | Return instruction asks for its target kind |
| flags_q | output | 16 | Current flags word |
| allow | output | 1 | Presented instruction may execute |
| gp_fault | output | 1 | General-protection fault for the presented instruction |
| gp_code | output | 16 | Error code accompanying the fault |
| link_sel | output | 1 | Return kind: 1 return to linked task, 0 in-task |

## Verification
The hardest situation to reach is a faulting instruction that arrives in the same cycle as a task event, because the event must be dropped rather than applied. The vector table places a privileged op at a non-zero level alongside an interrupt event while the nested-task bit is set, then repeats the op at level 0 to show that the clear does take effect there. Restores are driven at every relation of CPL to the I/O level, with all-ones and all-zeros data, so that each protected bit is seen both kept and loaded.

// File: rtl/sysflag_gate.sv
module sysflag_gate #(
  parameter int          FW       = 16,
  parameter logic [15:0] RST_WORD = 16'h0002,
  parameter int          IO_LO    = 12,
  parameter int          NT_POS   = 14,
  parameter int          IE_POS   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cpl,
  input  logic          op_valid,
  input  logic [1:0]    op_class,
  input  logic [FW-1:0] wr_data,
  input  logic          ev_task_call,
  input  logic          ev_int_plain,
  input  logic          ev_return,
  output logic [FW-1:0] flags_q,
  output logic          allow,
  output logic          gp_fault,
  output logic [FW-1:0] gp_code,
  output logic          link_sel
);
  localparam logic [1:0] C_ORD = 2'b00, C_PRIV = 2'b01, C_TRUST = 2'b10, C_REST = 2'b11;
  localparam int IO_HI = IO_LO + 1;

  logic [1:0]    iopl;
  logic          ring0, inside_io, permit;
  logic [FW-1:0] rest_word, nxt;

  assign iopl      = flags_q[IO_HI:IO_LO];
  assign ring0     = (cpl == 2'd0);
  assign inside_io = (cpl <= iopl);

  always_comb begin
    case (op_class)
      C_PRIV:  permit = ring0;
      C_TRUST: permit = inside_io;
      default: permit = 1'b1;
    endcase
  end

  assign allow    = op_valid & permit;
  assign gp_fault = op_valid & ~permit;
  assign gp_code  = '0;
  assign link_sel = ev_return & flags_q[NT_POS];

  always_comb begin
    rest_word          = wr_data;
    rest_word[FW-1]    = 1'b0;
    rest_word[1]       = 1'b1;
    if (!ring0)     rest_word[IO_HI:IO_LO] = iopl;
    if (!inside_io) rest_word[IE_POS]      = flags_q[IE_POS];
    nxt = (op_valid && op_class == C_REST) ? rest_word : flags_q;
    if (ev_task_call)      nxt[NT_POS] = 1'b1;
    else if (ev_int_plain) nxt[NT_POS] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flags_q <= RST_WORD[FW-1:0];
    else if (!gp_fault) flags_q <= nxt;
  end
endmodule

// File: rtl/sysflag_gate_chk.sv
module sysflag_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cpl,
  input logic        op_valid,
  input logic [1:0]  op_class,
  input logic        ev_task_call,
  input logic        ev_int_plain,
  input logic        ev_return,
  input logic [15:0] flags_q,
  input logic        allow,
  input logic        gp_fault,
  input logic        link_sel
);
  a_r2_priv_ring0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'b01 && cpl != 2'd0) |-> (gp_fault && !allow));
  a_r3_trusted_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'b10) |-> (allow == (cpl <= flags_q[13:12])));
  a_r4_iopl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'b11 && cpl != 2'd0) |=> (flags_q[13:12] == $past(flags_q[13:12])));
  a_r5_ie_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'b11 && cpl > flags_q[13:12]) |=> (flags_q[9] == $past(flags_q[9])));
  a_r6_nt_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_task_call && !gp_fault) |=> flags_q[14]);
  a_r7_nt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_int_plain && !ev_task_call && !gp_fault) |=> !flags_q[14]);
  a_r8_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_sel |-> (ev_return && flags_q[14]));
  a_r9_fault_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |=> (flags_q == $past(flags_q)));
  a_r9_fault_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> op_valid);
  a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[1] && !flags_q[15]));
endmodule

bind sysflag_gate sysflag_gate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpl(cpl), .op_valid(op_valid), .op_class(op_class),
  .ev_task_call(ev_task_call), .ev_int_plain(ev_int_plain), .ev_return(ev_return),
  .flags_q(flags_q), .allow(allow), .gp_fault(gp_fault), .link_sel(link_sel)
);

// File: tb/sysflag_gate_tb_top.sv
module sysflag_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpl = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_class = '0;
  logic [15:0] wr_data = '0;
  logic        ev_task_call = 1'b0, ev_int_plain = 1'b0, ev_return = 1'b0;
  logic [15:0] flags_q, gp_code;
  logic        allow, gp_fault, link_sel;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sysflag_gate dut_i (.*);

  // {cpl, class, data, call, intr, allow, fault, flags after}
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 2'b11, 16'h3202, 1'b0, 1'b0, 1'b1, 1'b0, 16'h3202}, // R4 R5 load at ring 0
    {2'd3, 2'b10, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h3202}, // R3 3<=3
    {2'd3, 2'b01, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h3202}, // R2
    {2'd3, 2'b11, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h3002}, // R4 kept, R5 loaded
    {2'd0, 2'b11, 16'h12D5, 1'b0, 1'b0, 1'b1, 1'b0, 16'h12D7}, // R10 bit1 forced
    {2'd2, 2'b10, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h12D7}, // R3 2>1
    {2'd1, 2'b10, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h12D7}, // R3 1<=1
    {2'd2, 2'b11, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 16'h5FFF}, // R10 bit15 zero, R4 kept
    {2'd2, 2'b11, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1202}, // R5 IE kept
    {2'd0, 2'b00, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h5202}, // R6 R11
    {2'd1, 2'b01, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h5202}, // R9 event dropped
    {2'd0, 2'b01, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1202}, // R7
    {2'd3, 2'b00, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h5202}, // R6 priority
    {2'd0, 2'b11, 16'h4002, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0002}, // R7 over restore
    {2'd1, 2'b10, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0002}, // R3 1>0
    {2'd0, 2'b10, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0002}  // R3 0<=0
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", flags_q, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", flags_q, 16'h0002);

    for (int i = 0; i < NV; i++) begin
      cpl = VEC[i][39:38]; op_class = VEC[i][37:36]; wr_data = VEC[i][35:20];
      ev_task_call = VEC[i][19]; ev_int_plain = VEC[i][18]; op_valid = 1'b1;
      #1;
      chk($sformatf("R2/R3/R11 allow vec%0d", i), {15'd0, allow}, {15'd0, VEC[i][17]});
      chk($sformatf("R2/R3/R9 fault vec%0d", i), {15'd0, gp_fault}, {15'd0, VEC[i][16]});
      if (gp_fault) chk("R2 error code", gp_code, 16'h0000);
      @(negedge clk);
      chk($sformatf("R4-R10 flags vec%0d", i), flags_q, VEC[i][15:0]);
    end

    // R11: no valid op, privileged class at ring 3
    op_valid = 1'b0; op_class = 2'b01; cpl = 2'd3; ev_task_call = 1'b0; ev_int_plain = 1'b0;
    #1;
    chk("R11 idle no fault", {15'd0, gp_fault}, 16'd0);
    chk("R11 idle no allow", {15'd0, allow}, 16'd0);
    @(negedge clk);

    // R8: return kind
    ev_task_call = 1'b1; @(negedge clk); ev_task_call = 1'b0;
    ev_return = 1'b1; #1;
    chk("R8 linked return", {15'd0, link_sel}, 16'd1);
    ev_return = 1'b0; #1;
    chk("R8 no return request", {15'd0, link_sel}, 16'd0);
    ev_int_plain = 1'b1; @(negedge clk); ev_int_plain = 1'b0;
    ev_return = 1'b1; #1;
    chk("R8 in-task return", {15'd0, link_sel}, 16'd0);
    ev_return = 1'b0;

    // R1: reset again from a modified word
    op_valid = 1'b1; op_class = 2'b11; cpl = 2'd0; wr_data = 16'h7FFF;
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0; @(negedge clk);
    chk("R1 reset restores word", flags_q, 16'h0002);
    rst_n = 1'b1; @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule